// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Controller

This block holds an interrupt enable register and an interrupt status register for each of several localities, and drives one shared level interrupt line. Event sources elsewhere in the chip send single-cycle pulses. Each pulse carries a locality tag and a vector of event bits. An event bit is captured in the tagged locality's status register only when that locality has both its master enable and that bit's own enable set. Capturing any bit raises the line.

Software reaches the registers through a simple write port and a combinational read port. Each port is addressed by locality and by register select. Only the locality that currently owns the interface may change its enable or status register. Status bits are cleared by writing ones to them. The line drops when a clearing write leaves the writer's status register at zero. A read-only vector register returns the configured line number for every locality.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset, every locality's enable register reads 0x0000_0008 (polarity field, bits 4:3, = 2'b01 for low level; all enables clear), every status register reads 0, and `irqLine` is low.
- R2: An event bit is latched into the status register, and `irqLine` rises on the same clock edge, only when enable bit 31 (master) and that event's own enable bit are both set. The event bits are data-available (bit 0), valid-status (bit 1), locality-changed (bit 2) and command-ready (bit 7).
- R3: An event whose locality tag is NUM_LOC or greater (the no-locality codes) changes no register and does not raise the line.
- R4: A write to the enable register (select 0) or the status register (select 1) whose locality differs from `activeLoc` is ignored.
- R5: An enable write updates only bits 31, 7, 4:3, 2, 1 and 0 and keeps every other bit of the register.
- R6: Writing a one to a status bit clears it. Zero bits in the written word and bits outside the four event positions leave the status unchanged.
- R7: `irqLine` falls on the edge of a status write that brings the writer's nonzero status to zero. It stays high while any bit of that status remains set.
- R8: The vector register (select 2) reads back the parameter VECTOR (0 to 15) for every valid locality, and writes to it have no effect.
- R9: An event that arrives in the same cycle as a clear of the same bit wins: the bit stays set and the line stays high.
- R10: An event touches only the status register of the locality it is tagged with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| activeLoc | input | LOC_W | Locality that currently owns the interface (NUM_LOC or above means none) |
| evtValid | input | 1 | Event pulse qualifier |
| evtLoc | input | LOC_W | Locality tag of the event |
| evtBits | input | 32 | Event bits at their status positions |
| wrEn | input | 1 | Register write strobe |
| wrLoc | input | LOC_W | Locality the write is addressed to |
| wrSel | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| wrData | input | 32 | Write data |
| rdLoc | input | LOC_W | Locality the read is addressed to |
| rdSel | input | 2 | Register select for the read |
| rdData | output | 32 | Combinational read data (0 for an invalid locality or select 3) |
| irqLine | output | 1 | Shared interrupt line, active high |

## Verification
The bound checker watches several properties on every cycle. It checks that the line rises only after an event pulse and falls only after a status write. It checks that out-of-range events and writes from a non-owning locality leave all enable and status state untouched. It also checks that status never holds a bit outside the four event positions, and that the vector register always reads back VECTOR. The directed scenarios cover the behaviour that needs concrete values. These are the reset contents, the exact masking of an enable write, the per-bit enable gating, partial versus full clears and their effect on the line, the locality routing of events, and the tie where an event and a clear hit the same bit in one cycle.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int REG_W = 32;
  localparam int GLOBAL_BIT = 31;
  localparam logic [REG_W-1:0] EVT_MASK = 32'h0000_0087;
  localparam logic [REG_W-1:0] POL_MASK = 32'h0000_0018;
  localparam logic [REG_W-1:0] EN_WR_MASK = 32'h8000_0000 | POL_MASK | EVT_MASK;
  localparam logic [REG_W-1:0] EN_RESET = 32'h0000_0008;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic enWr;
    logic stsClr;
    logic evtHit;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
`timescale 1ns/1ps
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = $clog2(NUM_LOC + 1)
) (
  input  logic             evtValid,
  input  logic [LOC_W-1:0] evtLoc,
  input  logic             wrEn,
  input  logic [LOC_W-1:0] wrLoc,
  input  logic [1:0]       wrSel,
  input  logic [LOC_W-1:0] activeLoc,
  output strobe_t          strobes [NUM_LOC]
);
  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic ownerWr;
    assign ownerWr = wrEn && (wrLoc == LOC_W'(i)) && (activeLoc == LOC_W'(i));
    always_comb begin
      strobes[i].enWr   = ownerWr && (wrSel == SEL_ENABLE);
      strobes[i].stsClr = ownerWr && (wrSel == SEL_STATUS);
      strobes[i].evtHit = evtValid && (evtLoc == LOC_W'(i));
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
`timescale 1ns/1ps
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = $clog2(NUM_LOC + 1),
  parameter logic [3:0] VECTOR = 4'd5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes [NUM_LOC],
  input  logic [REG_W-1:0]         wrData,
  input  logic [REG_W-1:0]         evtBits,
  input  logic [LOC_W-1:0]         rdLoc,
  input  logic [1:0]               rdSel,
  output logic [REG_W-1:0]         rdData,
  output logic                     irqLine,
  output logic [NUM_LOC*REG_W-1:0] enAll,
  output logic [NUM_LOC*REG_W-1:0] stsAll
);
  logic [REG_W-1:0] enReg  [NUM_LOC];
  logic [REG_W-1:0] stsReg [NUM_LOC];
  logic [NUM_LOC-1:0] setReq;
  logic [NUM_LOC-1:0] zeroReq;

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic [REG_W-1:0] hitBits;
    logic [REG_W-1:0] clrBits;
    logic [REG_W-1:0] stsNext;
    logic [REG_W-1:0] enNext;

    always_comb begin
      hitBits = '0;
      if (strobes[i].evtHit && enReg[i][GLOBAL_BIT])
        hitBits = evtBits & EVT_MASK & enReg[i];
      clrBits = strobes[i].stsClr ? (wrData & EVT_MASK) : '0;
      stsNext = (stsReg[i] & ~clrBits) | hitBits;
      enNext  = strobes[i].enWr ? ((enReg[i] & ~EN_WR_MASK) | (wrData & EN_WR_MASK))
                                : enReg[i];
    end

    assign setReq[i]  = |hitBits;
    assign zeroReq[i] = (|clrBits) && (|stsReg[i]) && (stsNext == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[i]  <= EN_RESET;
        stsReg[i] <= '0;
      end else begin
        enReg[i]  <= enNext;
        stsReg[i] <= stsNext;
      end
    end

    assign enAll[i*REG_W +: REG_W]  = enReg[i];
    assign stsAll[i*REG_W +: REG_W] = stsReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          irqLine <= 1'b0;
    else if (|setReq)   irqLine <= 1'b1;
    else if (|zeroReq)  irqLine <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (rdLoc == LOC_W'(i)) begin
        case (rdSel)
          SEL_ENABLE: rdData = enReg[i];
          SEL_STATUS: rdData = stsReg[i];
          SEL_VECTOR: rdData = REG_W'(VECTOR);
          default:    rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_status_ctl.sv
`timescale 1ns/1ps
module irq_status_ctl
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = $clog2(NUM_LOC + 1),
  parameter logic [3:0] VECTOR = 4'd5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             evtValid,
  input  logic [LOC_W-1:0] evtLoc,
  input  logic [31:0]      evtBits,
  input  logic             wrEn,
  input  logic [LOC_W-1:0] wrLoc,
  input  logic [1:0]       wrSel,
  input  logic [31:0]      wrData,
  input  logic [LOC_W-1:0] rdLoc,
  input  logic [1:0]       rdSel,
  output logic [31:0]      rdData,
  output logic             irqLine
);
  strobe_t strobes [NUM_LOC];
  logic [NUM_LOC*REG_W-1:0] enAll;
  logic [NUM_LOC*REG_W-1:0] stsAll;

  irqc_ctrl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_ctrl (
    .evtValid (evtValid),
    .evtLoc   (evtLoc),
    .wrEn     (wrEn),
    .wrLoc    (wrLoc),
    .wrSel    (wrSel),
    .activeLoc(activeLoc),
    .strobes  (strobes)
  );

  irqc_datapath #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VECTOR(VECTOR)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .evtBits(evtBits),
    .rdLoc  (rdLoc),
    .rdSel  (rdSel),
    .rdData (rdData),
    .irqLine(irqLine),
    .enAll  (enAll),
    .stsAll (stsAll)
  );
endmodule

// File: rtl/irq_status_ctl_chk.sv
`timescale 1ns/1ps
module irq_status_ctl_chk
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = $clog2(NUM_LOC + 1),
  parameter logic [3:0] VECTOR = 4'd5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [LOC_W-1:0]         activeLoc,
  input logic                     evtValid,
  input logic [LOC_W-1:0]         evtLoc,
  input logic                     wrEn,
  input logic [LOC_W-1:0]         wrLoc,
  input logic [1:0]               wrSel,
  input logic [LOC_W-1:0]         rdLoc,
  input logic [1:0]               rdSel,
  input logic [31:0]              rdData,
  input logic                     irqLine,
  input logic [NUM_LOC*REG_W-1:0] enAll,
  input logic [NUM_LOC*REG_W-1:0] stsAll
);
  localparam logic [NUM_LOC*REG_W-1:0] STS_ALLOWED = {NUM_LOC{EVT_MASK}};

  // R2
  line_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqLine) |-> $past(evtValid));

  // R3
  bad_loc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtLoc >= LOC_W'(NUM_LOC) && !wrEn) |=> ($stable(stsAll) && $stable(irqLine)));

  // R4
  foreign_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrLoc != activeLoc && !evtValid) |=> ($stable(stsAll) && $stable(enAll)));

  // R6
  sts_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsAll & ~STS_ALLOWED) == '0);

  // R7
  line_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqLine) |-> $past(wrEn && wrSel == SEL_STATUS));

  // R8
  vector_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_VECTOR && rdLoc < LOC_W'(NUM_LOC)) |-> rdData == 32'(VECTOR));
endmodule

bind irq_status_ctl irq_status_ctl_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rstN(rstN), .activeLoc(activeLoc), .evtValid(evtValid), .evtLoc(evtLoc),
  .wrEn(wrEn), .wrLoc(wrLoc), .wrSel(wrSel), .rdLoc(rdLoc), .rdSel(rdSel),
  .rdData(rdData), .irqLine(irqLine), .enAll(enAll), .stsAll(stsAll)
);

// File: tb/irq_status_ctl_tb.sv
`timescale 1ns/1ps
module irq_status_ctl_tb;
  localparam int NUM_LOC = 5;
  localparam int LOC_W = 3;
  localparam logic [3:0] VEC = 4'd5;

  logic clk = 0;
  logic rstN = 0;
  logic [LOC_W-1:0] activeLoc = 3'd7;
  logic evtValid = 0;
  logic [LOC_W-1:0] evtLoc = 0;
  logic [31:0] evtBits = 0;
  logic wrEn = 0;
  logic [LOC_W-1:0] wrLoc = 0;
  logic [1:0] wrSel = 0;
  logic [31:0] wrData = 0;
  logic [LOC_W-1:0] rdLoc = 0;
  logic [1:0] rdSel = 0;
  logic [31:0] rdData;
  logic irqLine;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_ctl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .VECTOR(VEC)) u_dut (
    .clk(clk), .rstN(rstN), .activeLoc(activeLoc), .evtValid(evtValid), .evtLoc(evtLoc),
    .evtBits(evtBits), .wrEn(wrEn), .wrLoc(wrLoc), .wrSel(wrSel), .wrData(wrData),
    .rdLoc(rdLoc), .rdSel(rdSel), .rdData(rdData), .irqLine(irqLine)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] loc, input logic [1:0] sel, output logic [31:0] v);
    rdLoc = loc;
    rdSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [2:0] loc, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrLoc = loc; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic ev(input logic [2:0] loc, input logic [31:0] bits);
    @(negedge clk);
    evtValid = 1; evtLoc = loc; evtBits = bits;
    @(negedge clk);
    evtValid = 0;
  endtask

  task automatic evClr(input logic [2:0] loc, input logic [31:0] bits, input logic [31:0] clr);
    @(negedge clk);
    evtValid = 1; evtLoc = loc; evtBits = bits;
    wrEn = 1; wrLoc = loc; wrSel = 2'd1; wrData = clr;
    @(negedge clk);
    evtValid = 0; wrEn = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < NUM_LOC; i++) begin
      rd(3'(i), 2'd0, v); chk("R1 enable reset", v, 32'h8);
      rd(3'(i), 2'd1, v); chk("R1 status reset", v, 32'h0);
    end
    chk("R1 line reset", {31'b0, irqLine}, 32'h0);
  endtask

  task automatic t_enable_mask();
    logic [31:0] v;
    activeLoc = 3'd0;
    wr(3'd0, 2'd0, 32'hFFFF_FFFF);
    rd(3'd0, 2'd0, v); chk("R5 enable all ones", v, 32'h8000_009F);
    wr(3'd0, 2'd0, 32'h0000_0100);
    rd(3'd0, 2'd0, v); chk("R5 enable non-field bits", v, 32'h0);
  endtask

  task automatic t_gating();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h0000_0080);
    ev(3'd0, 32'h80);
    rd(3'd0, 2'd1, v); chk("R2 no master enable", v, 32'h0);
    chk("R2 line low without master", {31'b0, irqLine}, 32'h0);
    wr(3'd0, 2'd0, 32'h8000_0080);
    ev(3'd0, 32'h02);
    rd(3'd0, 2'd1, v); chk("R2 bit not enabled", v, 32'h0);
    ev(3'd0, 32'h80);
    rd(3'd0, 2'd1, v); chk("R2 enabled event latched", v, 32'h80);
    chk("R2 line high", {31'b0, irqLine}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(3'd0, 2'd0, 32'h8000_0084);
    ev(3'd0, 32'h04);
    rd(3'd0, 2'd1, v); chk("R2 second event", v, 32'h84);
    wr(3'd0, 2'd1, 32'h0000_0100);
    rd(3'd0, 2'd1, v); chk("R6 unsupported clear ignored", v, 32'h84);
    wr(3'd0, 2'd1, 32'h80);
    rd(3'd0, 2'd1, v); chk("R6 partial clear", v, 32'h04);
    chk("R7 line stays with bits left", {31'b0, irqLine}, 32'h1);
    wr(3'd0, 2'd1, 32'h04);
    rd(3'd0, 2'd1, v); chk("R6 full clear", v, 32'h0);
    chk("R7 line drops at zero", {31'b0, irqLine}, 32'h0);
  endtask

  task automatic t_foreign();
    logic [31:0] v;
    ev(3'd0, 32'h80);
    activeLoc = 3'd1;
    wr(3'd0, 2'd1, 32'h80);
    rd(3'd0, 2'd1, v); chk("R4 foreign status write", v, 32'h80);
    wr(3'd0, 2'd0, 32'h0);
    rd(3'd0, 2'd0, v); chk("R4 foreign enable write", v, 32'h8000_0084);
    wr(3'd2, 2'd0, 32'hFFFF_FFFF);
    rd(3'd2, 2'd0, v); chk("R4 non-owner enable write", v, 32'h8);
    activeLoc = 3'd0;
    wr(3'd0, 2'd1, 32'h80);
    rd(3'd0, 2'd1, v); chk("R4 owner clear", v, 32'h0);
  endtask

  task automatic t_badloc();
    logic [31:0] v;
    ev(3'd7, 32'h87);
    ev(3'd5, 32'h87);
    for (int i = 0; i < NUM_LOC; i++) begin
      rd(3'(i), 2'd1, v); chk("R3 invalid tag ignored", v, 32'h0);
    end
    chk("R3 line unchanged", {31'b0, irqLine}, 32'h0);
  endtask

  task automatic t_routing();
    logic [31:0] v;
    activeLoc = 3'd1;
    wr(3'd1, 2'd0, 32'h8000_0080);
    ev(3'd1, 32'h80);
    rd(3'd1, 2'd1, v); chk("R10 tagged locality set", v, 32'h80);
    rd(3'd0, 2'd1, v); chk("R10 other locality untouched", v, 32'h0);
  endtask

  task automatic t_tie();
    logic [31:0] v;
    evClr(3'd1, 32'h80, 32'h80);
    rd(3'd1, 2'd1, v); chk("R9 event beats clear", v, 32'h80);
    chk("R9 line held", {31'b0, irqLine}, 32'h1);
    wr(3'd1, 2'd1, 32'h80);
    rd(3'd1, 2'd1, v); chk("R9 later clear", v, 32'h0);
    chk("R7 line low after clear", {31'b0, irqLine}, 32'h0);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    wr(3'd1, 2'd2, 32'h0000_000F);
    for (int i = 0; i < NUM_LOC; i++) begin
      rd(3'(i), 2'd2, v); chk("R8 vector readback", v, 32'(VEC));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_enable_mask();
    t_gating();
    t_clear();
    t_foreign();
    t_badloc();
    t_routing();
    t_tie();
    t_vector();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule